// File: doc/BRIEF.md
# Character Blink and Reverse-Video Gate

This block sits in the pixel path of an on-screen character display, after the font lookup. It counts vertical sync pulses to produce a blink phase. Each character pixel then passes through the block, which applies that phase and the character's attribute bits. The result is a final character bit and a blanking (background) bit, registered once.

A two-bit period selector sets the blink period to a whole number of fields. The character is visible for the first six tenths of the period and hidden for the remainder. Two global enables gate the per-character blink and reverse attributes. One reserved character code always yields an empty cell. Raster counting and font storage are upstream and are not part of this block.

Top module: `blink_reverse_ctrl`

## Requirements
- R1: `period_sel` selects the blink period in fields: 0 gives 25, 1 gives 30, 2 gives 50 and 3 gives 60. The field counter counts `vsync_tick` pulses and wraps to 0 after the last field of the period.
- R2: The blink phase is visible while the field count is below period*6/10 (15, 18, 30 or 36 fields). It is hidden from that count up to the end of the period.
- R3: A character is hidden (both outputs 0) only when `blink_en` is 1, `attr_blink` is 1 and the phase is hidden. With either bit at 0, the phase has no effect.
- R4: Reverse video applies only when `reverse_en` and `attr_reverse` are both 1. In that case `char_out` = `pix_cell` AND NOT `pix_char`, and `blank_out` = `pix_cell`.
- R5: When `char_code` equals 8'hFE, both outputs are 0 whatever the attributes, enables and pixels are. Other codes (for example FF, FD, 7E) are not suppressed.
- R6: The field counter is at 0 after reset. It also returns to 0 on the clock edge after `period_sel` differs from the value in use.
- R7: With no suppression and no reverse, `char_out` = `pix_char` and `blank_out` = `pix_blank`.
- R8: The outputs are registered, with one clock of latency from the pixel inputs. Both outputs are 0 while reset is held.
- R9: The conditions take effect in this order of priority: reserved code first, then blink hiding, then reverse video.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync_tick | input | 1 | One-cycle pulse per field |
| period_sel | input | 2 | Blink period select |
| blink_en | input | 1 | Global blink enable |
| reverse_en | input | 1 | Global reverse-video enable |
| pix_char | input | 1 | Font pixel of the current character |
| pix_blank | input | 1 | Upstream blanking/background bit |
| pix_cell | input | 1 | High inside the character cell area |
| attr_blink | input | 1 | Character blink attribute |
| attr_reverse | input | 1 | Character reverse attribute |
| char_code | input | 8 | Code of the current character |
| char_out | output | 1 | Final character bit |
| blank_out | output | 1 | Final blanking bit |

## Verification
The bench walks every period setting across a full period and past the wrap. It checks the first hidden field and the last visible one, so an off-by-one in the 60% threshold or in the wrap count shows up as a wrong visibility on a boundary field. It changes the period while the count sits deep in the hidden region and expects an immediately visible field; a design that kept counting would stay dark. All 128 combinations of enables, attributes and pixels are swept with the reserved code and three near-miss codes, in both phases. Any mis-decoded code bit, any enable that is ignored, or any wrong priority shows up as a wrong output pair.

// File: rtl/blink_pkg.sv
// Shared helpers for the blink/reverse controller.
// Assumes period_sel is a two-bit field; all values are legal.
package blink_pkg;
    // Number of fields in one blink period for a given selector.
    function automatic int period_of(input logic [1:0] sel);
        case (sel)
            2'd0:    period_of = 25;
            2'd1:    period_of = 30;
            2'd2:    period_of = 50;
            default: period_of = 60;
        endcase
    endfunction

    // Number of visible fields at the start of a period (six tenths).
    function automatic int on_of(input logic [1:0] sel);
        on_of = (period_of(sel) * 6) / 10;
    endfunction
endpackage

// File: rtl/blink_phase_gen.sv
// Field counter that produces the blink phase.
// Counts vsync_tick pulses modulo the selected period and reports
// whether the current field lies in the visible part. Assumes
// vsync_tick is a single-cycle pulse and CNT_W can hold 59.
module blink_phase_gen
    import blink_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vsync_tick,
    input  logic [1:0] period_sel,
    output logic       show_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       sel_q;
    logic             last_field;

    assign last_field = (int'(cnt_q) == period_of(sel_q) - 1);

    // Track the selector in use and count fields, restarting on a change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sel_q <= 2'd0;
        end else if (period_sel != sel_q) begin
            cnt_q <= '0;
            sel_q <= period_sel;
        end else if (vsync_tick) begin
            cnt_q <= last_field ? '0 : cnt_q + 1'b1;
        end
    end

    // Visible for the first six tenths of the period.
    always_comb show_o = (int'(cnt_q) < on_of(sel_q));

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < period_of(sel_q));

    assert_period_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_tick && last_field && period_sel == sel_q) |=> cnt_q == '0);

    assert_sel_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (period_sel != sel_q) |=> (cnt_q == '0 && sel_q == $past(period_sel)));
endmodule

// File: rtl/px_attr_mixer.sv
// Combinational pixel mixer.
// Applies reserved-code suppression, blink hiding and reverse video
// (in that priority) to one character pixel. Assumes pix_cell covers
// the full cell area for the current character.
module px_attr_mixer #(
    parameter int          CODE_W     = 8,
    parameter logic [7:0]  BLANK_CODE = 8'hFE
) (
    input  logic              show,
    input  logic              blink_en,
    input  logic              reverse_en,
    input  logic              pix_char,
    input  logic              pix_blank,
    input  logic              pix_cell,
    input  logic              attr_blink,
    input  logic              attr_reverse,
    input  logic [CODE_W-1:0] char_code,
    output logic              char_nx,
    output logic              blank_nx
);
    logic is_void;
    logic hide;
    logic rev;

    // Decode the three conditions separately.
    always_comb begin
        is_void = (char_code == CODE_W'(BLANK_CODE));
        hide    = blink_en && attr_blink && !show;
        rev     = reverse_en && attr_reverse;
    end

    // Select the output pair by priority.
    always_comb begin
        if (is_void || hide) begin
            char_nx  = 1'b0;
            blank_nx = 1'b0;
        end else if (rev) begin
            char_nx  = pix_cell & ~pix_char;
            blank_nx = pix_cell;
        end else begin
            char_nx  = pix_char;
            blank_nx = pix_blank;
        end
    end
endmodule

// File: rtl/blink_reverse_ctrl.sv
// Top of the character blink and reverse-video gate.
// Combines the field-based blink phase with per-character attributes
// and registers the final character and blanking bits (one clock).
// Assumes synchronous active-low reset and a one-cycle vsync_tick.
module blink_reverse_ctrl
    import blink_pkg::*;
#(
    parameter int         CNT_W      = 6,
    parameter int         CODE_W     = 8,
    parameter logic [7:0] BLANK_CODE = 8'hFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_tick,
    input  logic [1:0]        period_sel,
    input  logic              blink_en,
    input  logic              reverse_en,
    input  logic              pix_char,
    input  logic              pix_blank,
    input  logic              pix_cell,
    input  logic              attr_blink,
    input  logic              attr_reverse,
    input  logic [CODE_W-1:0] char_code,
    output logic              char_out,
    output logic              blank_out
);
    logic show;
    logic char_nx;
    logic blank_nx;

    blink_phase_gen #(.CNT_W(CNT_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .vsync_tick (vsync_tick),
        .period_sel (period_sel),
        .show_o     (show)
    );

    px_attr_mixer #(.CODE_W(CODE_W), .BLANK_CODE(BLANK_CODE)) u_mix (
        .show         (show),
        .blink_en     (blink_en),
        .reverse_en   (reverse_en),
        .pix_char     (pix_char),
        .pix_blank    (pix_blank),
        .pix_cell     (pix_cell),
        .attr_blink   (attr_blink),
        .attr_reverse (attr_reverse),
        .char_code    (char_code),
        .char_nx      (char_nx),
        .blank_nx     (blank_nx)
    );

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_out  <= 1'b0;
            blank_out <= 1'b0;
        end else begin
            char_out  <= char_nx;
            blank_out <= blank_nx;
        end
    end

    assert_blank_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (char_code == CODE_W'(BLANK_CODE)) |=> (!char_out && !blank_out));

    assert_hide_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_en && attr_blink && !show) |=> (!char_out && !blank_out));

    assert_reverse_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reverse_en && attr_reverse && char_code != CODE_W'(BLANK_CODE)
         && !(blink_en && attr_blink && !show))
        |=> (blank_out == $past(pix_cell)));

    assert_pass_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(blink_en && attr_blink) && !(reverse_en && attr_reverse)
         && char_code != CODE_W'(BLANK_CODE))
        |=> (char_out == $past(pix_char) && blank_out == $past(pix_blank)));
endmodule

// File: tb/sim_blink_reverse_ctrl.sv
module sim_blink_reverse_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsync_tick = 1'b0;
    logic [1:0] period_sel = 2'd0;
    logic       blink_en = 1'b0, reverse_en = 1'b0;
    logic       pix_char = 1'b0, pix_blank = 1'b0, pix_cell = 1'b0;
    logic       attr_blink = 1'b0, attr_reverse = 1'b0;
    logic [7:0] char_code = 8'h41;
    logic       char_out, blank_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    blink_reverse_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .vsync_tick(vsync_tick),
        .period_sel(period_sel), .blink_en(blink_en), .reverse_en(reverse_en),
        .pix_char(pix_char), .pix_blank(pix_blank), .pix_cell(pix_cell),
        .attr_blink(attr_blink), .attr_reverse(attr_reverse),
        .char_code(char_code), .char_out(char_out), .blank_out(blank_out)
    );

    function automatic int period_m(input int s);
        case (s)
            0: period_m = 25;
            1: period_m = 30;
            2: period_m = 50;
            default: period_m = 60;
        endcase
    endfunction

    // Expected output pair from the requirements (R3, R4, R5, R7, R9).
    function automatic logic [1:0] expect_pair(input bit vis, input bit be,
        input bit re, input bit ch, input bit bl, input bit ce,
        input bit ab, input bit ar, input logic [7:0] code);
        if (code == 8'hFE) return 2'b00;
        if (be && ab && !vis) return 2'b00;
        if (re && ar) return {ce & ~ch, ce};
        return {ch, bl};
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got char/blank=%b expected %b", req, act, exp);
        end
    endtask

    task automatic field_pulse();
        vsync_tick = 1'b1;
        @(negedge clk);
        vsync_tick = 1'b0;
    endtask

    // Probe the phase: blinking char pixel, enables on, no reverse.
    task automatic probe_phase(input string req, input bit vis);
        blink_en = 1; reverse_en = 0; attr_blink = 1; attr_reverse = 0;
        pix_char = 1; pix_blank = 1; pix_cell = 1; char_code = 8'h30;
        @(negedge clk);
        check(req, {char_out, blank_out}, vis ? 2'b11 : 2'b00);
        // Same field, blink attribute off: phase must have no effect (R3).
        attr_blink = 0;
        @(negedge clk);
        check("R3", {char_out, blank_out}, 2'b11);
    endtask

    task automatic sweep(input bit vis);
        logic [7:0] codes [4];
        codes[0] = 8'hFE; codes[1] = 8'hFF; codes[2] = 8'hFD; codes[3] = 8'h7E;
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 128; i++) begin
                logic [6:0] v;
                v = 7'(i);
                {blink_en, reverse_en, pix_char, pix_blank, pix_cell,
                 attr_blink, attr_reverse} = v;
                char_code = codes[k];
                @(negedge clk);
                check(k == 0 ? "R5" : "R9",
                      {char_out, blank_out},
                      expect_pair(vis, v[6], v[5], v[4], v[3], v[2], v[1], v[0], codes[k]));
            end
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        pix_char = 1; pix_blank = 1; pix_cell = 1;
        repeat (3) @(negedge clk);
        check("R8", {char_out, blank_out}, 2'b00);     // reset state
        rst_n = 1'b1;
        // R8 latency: input change appears after exactly one edge.
        blink_en = 0; reverse_en = 0; char_code = 8'h41;
        pix_char = 1; pix_blank = 0;
        @(negedge clk);
        check("R8", {char_out, blank_out}, 2'b10);
        pix_char = 0; pix_blank = 1;
        #1 check("R8", {char_out, blank_out}, 2'b10);   // not yet
        @(negedge clk);
        check("R7", {char_out, blank_out}, 2'b01);

        // R1/R2: every period, across the wrap. R6 via the selector change.
        for (int s = 0; s < 4; s++) begin
            int per, on;
            per = period_m(s);
            on = (per * 6) / 10;
            period_sel = 2'(s);
            @(negedge clk);
            for (int f = 0; f < per + 5; f++) begin
                probe_phase((f % per) == on || (f % per) == on - 1 ? "R2" : "R1",
                            (f % per) < on);
                field_pulse();
            end
        end

        // R6: change selector while deep in the hidden region.
        period_sel = 2'd3;
        @(negedge clk);
        for (int f = 0; f < 40; f++) field_pulse();
        probe_phase("R6", 1'b0);
        period_sel = 2'd0;
        @(negedge clk);
        probe_phase("R6", 1'b1);

        // Exhaustive mixer sweep in the visible phase (field 0 of 25).
        sweep(1'b1);
        // Advance to field 15: first hidden field of a 25-field period.
        for (int f = 0; f < 15; f++) field_pulse();
        sweep(1'b0);

        // R4 explicit spot check in the visible phase.
        period_sel = 2'd1;
        @(negedge clk);
        blink_en = 1; attr_blink = 1; reverse_en = 1; attr_reverse = 1;
        pix_cell = 1; pix_char = 1; pix_blank = 0; char_code = 8'h10;
        @(negedge clk);
        check("R4", {char_out, blank_out}, 2'b01);
        pix_char = 0;
        @(negedge clk);
        check("R4", {char_out, blank_out}, 2'b11);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule